// File: doc/BRIEF.md
# Serial LED shift-out controller

This block feeds an external serial-in, parallel-out register that holds 17 LED or GPIO output bits. It makes a serial clock and a serial data line from the system clock. The bit rate is set by a programmable divisor, and a programmable delay sets when data changes after each falling clock edge. Software reaches four small registers through a simple write port with a combinational read-back.

In manual mode, software writes a 17-bit pattern and the block shifts it out once. In flash mode, the block watches the 17 channel levels coming from a waveform generator bank. It shifts them out on its own whenever they differ from the last pattern sent. A busy bit is high for the length of every transfer. While it is high, data writes and mode writes are dropped.

After reset the last-sent pattern is all zeros. For that reason, flash mode stays silent until some channel goes high. Software that needs a known external state first sends an all-zero word in manual mode.

Top module: `serial_led_shifter`

## Requirements
- R1: After reset, `sclk_o` and `sdata_o` are 0, every register reads 0 and the busy bit is 0. Whenever no transfer is running, both serial lines stay at 0.
- R2: The divider register (address 1, bits 1:0) selects the bit period D: 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32 system clocks. In each bit period `sclk_o` is low for the first D/2 clocks and high for the last D/2.
- R3: A transfer sends 17 bits, bit 16 first and bit 0 last. `sdata_o` holds still while `sclk_o` is high.
- R4: The delay register is at address 2, bits 4:0, and holds a value V. Counting the first clock of a bit period (where `sclk_o` falls) as 0, the new bit appears on `sdata_o` at clock V+1. Before that, the previous bit is shown, or 0 for the first bit.
- R5: A delay value above D/2-2 is used as D/2-2. The divider and delay are captured when a transfer starts.
- R6: With the flash bit clear, a write to address 0 starts a transfer of `reg_wdata[16:0]`. From the next clock, bit 31 of address 0 reads 1 for exactly 17·D clocks. Bits 16:0 of address 0 read the last pattern sent.
- R7: While busy, writes to address 0 and to the mode register are ignored. The running waveform and the mode read-back are unaffected.
- R8: The mode register is at address 3. Bit 1 selects flash mode and bit 0 is the alternate chip-type select. Both bits read back as written, and writing the mode register alone starts nothing.
- R9: In flash mode, while idle, a transfer of `chan_lvl` starts on the clock after `chan_lvl` differs from the last pattern sent. With all-zero levels after reset, no transfer starts. A change during a transfer is sent right after that transfer ends.
- R10: In flash mode, writes to address 0 start nothing and leave the read-back pattern unchanged.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 data, 1 divider, 2 delay, 3 mode) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the addressed register |
| chan_lvl | input | 17 | Channel levels from the waveform generators |
| sclk_o | output | 1 | Serial clock to the external register |
| sdata_o | output | 1 | Serial data to the external register |

## Verification
The bench models every cycle of each transfer for all four divisors and for delays below, at and above the half-period limit. A design that got the saturation wrong would move data while the clock is high or at the rising edge, and one with a delay off by one would show the new bit a clock early or late. Writes are fired in the middle of a transfer. A design that let them through would either restart with a corrupted pattern or switch into flash mode mid-frame. Flash mode is exercised from reset with all-zero levels, where a wrong design would shift a useless frame. A change of levels in mid-transfer is also tested, where a wrong design would drop the second frame or cut the first one short.

// File: rtl/sled_pkg.sv
package sled_pkg;

   typedef enum logic [1:0] {
      SLED_DATA = 2'd0,
      SLED_DIV  = 2'd1,
      SLED_DLY  = 2'd2,
      SLED_MODE = 2'd3
   } sled_addr_e;

   localparam int SLED_FLASH_BIT = 1;
   localparam int SLED_ALT_BIT   = 0;

endpackage

// File: rtl/sled_regs.sv
module sled_regs
   import sled_pkg::*;
#(
   parameter int DIV_W = 2,
   parameter int DLY_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [1:0]       addr,
   input  logic [DIV_W-1:0] wdata_div,
   input  logic [DLY_W-1:0] wdata_dly,
   input  logic [1:0]       wdata_mode,
   input  logic             busy,
   output logic [DIV_W-1:0] div_q,
   output logic [DLY_W-1:0] dly_q,
   output logic             flash_q,
   output logic             alt_q,
   output logic             data_go
);

   sled_addr_e sel;
   assign sel = sled_addr_e'(addr);

   // a data write only launches a frame in manual mode and when idle
   assign data_go = wr && (sel == SLED_DATA) && !busy && !flash_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         dly_q   <= '0;
         flash_q <= 1'b0;
         alt_q   <= 1'b0;
      end else if (wr) begin
         case (sel)
            SLED_DIV:  div_q <= wdata_div;
            SLED_DLY:  dly_q <= wdata_dly;
            SLED_MODE: if (!busy) begin
               flash_q <= wdata_mode[SLED_FLASH_BIT];
               alt_q   <= wdata_mode[SLED_ALT_BIT];
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sled_timing.sv
module sled_timing #(
   parameter int DIV_W = 2,
   parameter int DLY_W = 5,
   parameter int PH_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [DIV_W-1:0] div_sel,
   input  logic [DLY_W-1:0] dly_val,
   output logic             sclk,
   output logic             load_stb,
   output logic             end_stb
);

   function automatic logic [PH_W-1:0] half_of(input logic [DIV_W-1:0] d);
      return PH_W'(2 << d);
   endfunction

   function automatic logic [PH_W-1:0] last_of(input logic [DIV_W-1:0] d);
      return PH_W'((4 << d) - 1);
   endfunction

   logic [PH_W-1:0]  ph_q;
   logic [DIV_W-1:0] div_l;
   logic [PH_W-1:0]  dly_l;
   logic [PH_W-1:0]  lim_c;
   logic [PH_W-1:0]  dly_c;

   // clamp the delay so data settles before the rising edge
   always_comb begin
      lim_c = half_of(div_sel) - PH_W'(2);
      if (32'(dly_val) > 32'(lim_c)) dly_c = lim_c;
      else                           dly_c = PH_W'(dly_val);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         div_l <= '0;
         dly_l <= '0;
      end else if (start) begin
         ph_q  <= '0;
         div_l <= div_sel;
         dly_l <= dly_c;
      end else if (run) begin
         ph_q  <= (ph_q == last_of(div_l)) ? '0 : ph_q + PH_W'(1);
      end
   end

   assign sclk     = run && (ph_q >= half_of(div_l));
   assign load_stb = run && (ph_q == dly_l);
   assign end_stb  = run && (ph_q == last_of(div_l));

endmodule

// File: rtl/sled_shift.sv
module sled_shift #(
   parameter int NBITS = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             manual_go,
   input  logic [NBITS-1:0] wr_pattern,
   input  logic             flash,
   input  logic [NBITS-1:0] chan,
   input  logic             load_stb,
   input  logic             end_stb,
   output logic             busy,
   output logic             start,
   output logic             sdata,
   output logic [NBITS-1:0] last_pat
);

   localparam int CNT_W = $clog2(NBITS);

   logic [NBITS-1:0] shreg_q;
   logic [CNT_W-1:0] bitcnt_q;
   logic             flash_go;
   logic [NBITS-1:0] next_pat;

   assign flash_go = flash && (chan != last_pat);
   assign start    = !busy && (manual_go || flash_go);
   assign next_pat = manual_go ? wr_pattern : chan;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         sdata    <= 1'b0;
         shreg_q  <= '0;
         bitcnt_q <= '0;
         last_pat <= '0;
      end else if (start) begin
         busy     <= 1'b1;
         shreg_q  <= next_pat;
         last_pat <= next_pat;
         bitcnt_q <= CNT_W'(NBITS - 1);
      end else if (busy) begin
         if (load_stb) begin
            sdata   <= shreg_q[NBITS-1];
            shreg_q <= {shreg_q[NBITS-2:0], 1'b0};
         end
         if (end_stb) begin
            if (bitcnt_q == '0) begin
               busy  <= 1'b0;
               sdata <= 1'b0;
            end else begin
               bitcnt_q <= bitcnt_q - CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/serial_led_shifter.sv
module serial_led_shifter
   import sled_pkg::*;
#(
   parameter int NBITS    = 17,
   parameter int DIV_W    = 2,
   parameter int DLY_W    = 5,
   parameter int DATA_W   = 32,
   parameter int BUSY_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NBITS-1:0]  chan_lvl,
   output logic              sclk_o,
   output logic              sdata_o
);

   localparam int MAX_DIV = 4 << ((1 << DIV_W) - 1);
   localparam int PH_W    = $clog2(MAX_DIV);

   if (NBITS < 2 || NBITS > BUSY_BIT) begin : g_bad_nbits
      $error("NBITS must lie between 2 and BUSY_BIT");
   end
   if (BUSY_BIT >= DATA_W) begin : g_bad_busy
      $error("BUSY_BIT must lie inside the data word");
   end
   if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
      $error("DIV_W must be 1 to 3");
   end
   if (DLY_W > DATA_W || DIV_W > DATA_W) begin : g_bad_fields
      $error("register fields wider than the data word");
   end

   logic [DIV_W-1:0] div_q;
   logic [DLY_W-1:0] dly_q;
   logic             flash_q;
   logic             alt_q;
   logic             data_go;
   logic             busy;
   logic             start;
   logic             load_stb;
   logic             end_stb;
   logic [NBITS-1:0] last_pat;

   wire unused_wdata = ^reg_wdata;

   sled_regs #(.DIV_W(DIV_W), .DLY_W(DLY_W)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .addr       (reg_addr),
      .wdata_div  (reg_wdata[DIV_W-1:0]),
      .wdata_dly  (reg_wdata[DLY_W-1:0]),
      .wdata_mode (reg_wdata[1:0]),
      .busy       (busy),
      .div_q      (div_q),
      .dly_q      (dly_q),
      .flash_q    (flash_q),
      .alt_q      (alt_q),
      .data_go    (data_go)
   );

   sled_timing #(.DIV_W(DIV_W), .DLY_W(DLY_W), .PH_W(PH_W)) i_timing (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .run      (busy),
      .div_sel  (div_q),
      .dly_val  (dly_q),
      .sclk     (sclk_o),
      .load_stb (load_stb),
      .end_stb  (end_stb)
   );

   sled_shift #(.NBITS(NBITS)) i_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .manual_go  (data_go),
      .wr_pattern (reg_wdata[NBITS-1:0]),
      .flash      (flash_q),
      .chan       (chan_lvl),
      .load_stb   (load_stb),
      .end_stb    (end_stb),
      .busy       (busy),
      .start      (start),
      .sdata      (sdata_o),
      .last_pat   (last_pat)
   );

   always_comb begin
      reg_rdata = '0;
      case (sled_addr_e'(reg_addr))
         SLED_DATA: begin
            reg_rdata[NBITS-1:0] = last_pat;
            reg_rdata[BUSY_BIT]  = busy;
         end
         SLED_DIV:  reg_rdata[DIV_W-1:0] = div_q;
         SLED_DLY:  reg_rdata[DLY_W-1:0] = dly_q;
         SLED_MODE: begin
            reg_rdata[SLED_FLASH_BIT] = flash_q;
            reg_rdata[SLED_ALT_BIT]   = alt_q;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sled_check.sv
module sled_check
   import sled_pkg::*;
#(
   parameter int NBITS = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [1:0]       reg_addr,
   input logic [NBITS-1:0] chan_lvl,
   input logic             busy,
   input logic             flash_q,
   input logic             alt_q,
   input logic [NBITS-1:0] last_pat,
   input logic             sclk_o,
   input logic             sdata_o
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sclk_o && !sdata_o));

   assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

   assert_manual_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && reg_wr && reg_addr == SLED_DATA && !flash_q) |=> busy);

   assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_addr == SLED_MODE) |=> $stable({flash_q, alt_q}));

   assert_pattern_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_addr == SLED_DATA) |=> $stable(last_pat));

   assert_flash_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && flash_q && chan_lvl != last_pat) |=> busy);

endmodule

bind serial_led_shifter sled_check #(.NBITS(NBITS)) i_sled_check (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .chan_lvl (chan_lvl),
   .busy     (busy),
   .flash_q  (flash_q),
   .alt_q    (alt_q),
   .last_pat (last_pat),
   .sclk_o   (sclk_o),
   .sdata_o  (sdata_o)
);

// File: tb/test_serial_led_shifter.sv
module test_serial_led_shifter;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 7;
   // {pattern[16:0], divider[1:0], delay[4:0]}
   localparam logic [23:0] VECS [0:NV-1] = '{
      {17'h1A5A5, 2'd0, 5'd0},
      {17'h0FFFF, 2'd1, 5'd2},
      {17'h10001, 2'd2, 5'd3},
      {17'h0B3C7, 2'd3, 5'd9},
      {17'h1FFFF, 2'd3, 5'd31},
      {17'h0AAAA, 2'd0, 5'd7},
      {17'h15555, 2'd1, 5'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [16:0] chan = '0;
   logic        sclk_o;
   logic        sdata_o;

   int n_checks = 0;
   int n_fail = 0;

   serial_led_shifter i_serial_led_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .chan_lvl  (chan),
      .sclk_o    (sclk_o),
      .sdata_o   (sdata_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 2'd0;
   endtask

   task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
      reg_addr = 2'd0;
   endtask

   // called at the falling edge right after the starting clock edge
   // mode 0: quiet, 1: data and mode writes mid-frame, 2: new levels mid-frame
   task automatic run_xfer(input logic [16:0] pat, input int div, input int dly,
                           input int mode, input logic [16:0] alt);
      int d  = 4 << div;
      int h  = d / 2;
      int de = (dly > h - 2) ? h - 2 : dly;
      int e_clk = 0;
      int e_dat = 0;
      int e_bsy = 0;
      for (int k = 0; k <= 17 * d; k++) begin
         int   ph = k % d;
         int   b  = k / d;
         logic eb, ec, ed;
         #1;
         eb = (k < 17 * d);
         ec = eb && (ph >= h);
         if (!eb)          ed = 1'b0;
         else if (ph > de) ed = pat[16-b];
         else if (b == 0)  ed = 1'b0;
         else              ed = pat[17-b];
         if (sclk_o !== ec) begin
            if (e_clk == 0) $display("sclk mismatch at cycle %0d: %b vs %b", k, sclk_o, ec);
            e_clk++;
         end
         if (sdata_o !== ed) begin
            if (e_dat == 0) $display("sdata mismatch at cycle %0d: %b vs %b", k, sdata_o, ed);
            e_dat++;
         end
         if (reg_addr == 2'd0 && reg_rdata[31] !== eb) e_bsy++;
         if (mode == 1 && k == 5) begin
            reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = {15'd0, pat ^ 17'h15555};
         end else if (mode == 1 && k == 9) begin
            reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'd2;
         end else begin
            reg_wr = 1'b0; reg_addr = 2'd0;
         end
         if (mode == 2 && k == 7) chan = alt;
         if (k < 17 * d) @(negedge clk);
      end
      chk("R2 sclk shape and period", e_clk, 0);
      chk("R3 R4 R5 sdata order and delay", e_dat, 0);
      chk("R6 busy window", e_bsy, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: quiet lines and cleared registers
      chk("R1 sclk after reset", {31'd0, sclk_o}, 0);
      chk("R1 sdata after reset", {31'd0, sdata_o}, 0);
      for (int a = 0; a < 4; a++) begin
         read_reg(2'(a), rd);
         chk("R1 register after reset", rd, 0);
      end

      // R9: flash from reset with all-zero levels stays silent
      do_write(2'd3, 32'd2);
      begin
         int act = 0;
         for (int i = 0; i < 40; i++) begin
            #1;
            if (sclk_o || reg_rdata[31]) act++;
            @(negedge clk);
         end
         chk("R9 no frame for zero levels", act, 0);
      end
      read_reg(2'd3, rd);
      chk("R8 flash bit reads back", rd, 32'd2);

      // R9: non-zero levels trigger, a change mid-frame follows directly
      chan = 17'h00013;
      @(negedge clk);
      run_xfer(17'h00013, 0, 0, 2, 17'h1C001);
      @(negedge clk);
      run_xfer(17'h1C001, 0, 0, 0, 17'h0);

      // R10: data write ignored in flash mode
      do_write(2'd0, 32'h0001FFFF);
      repeat (3) @(negedge clk);
      #1;
      chk("R10 no frame from data write", {31'd0, reg_rdata[31]}, 0);
      read_reg(2'd0, rd);
      chk("R10 pattern unchanged", rd, 32'h0001C001);

      // back to manual mode, then the vector table
      do_write(2'd3, 32'd0);
      for (int v = 0; v < NV; v++) begin
         logic [16:0] p;
         int dv, dl;
         p  = VECS[v][23:7];
         dv = int'(VECS[v][6:5]);
         dl = int'(VECS[v][4:0]);
         do_write(2'd1, 32'(dv));
         do_write(2'd2, 32'(dl));
         do_write(2'd0, {15'd0, p});
         run_xfer(p, dv, dl, 0, 17'h0);
         read_reg(2'd0, rd);
         chk("R6 data field reads last pattern", rd, {15'd0, p});
      end

      // R7: writes during a frame are dropped
      do_write(2'd1, 32'd0);
      do_write(2'd2, 32'd0);
      do_write(2'd0, 32'h0000F0F3);
      run_xfer(17'h0F0F3, 0, 0, 1, 17'h0);
      read_reg(2'd3, rd);
      chk("R7 mode write ignored while busy", rd, 0);
      read_reg(2'd0, rd);
      chk("R7 data write ignored while busy", rd, 32'h0000F0F3);

      // R8: alternate chip bit reads back and starts nothing
      do_write(2'd3, 32'd1);
      read_reg(2'd3, rd);
      chk("R8 alt bit reads back", rd, 32'd1);
      #1;
      chk("R8 mode write starts nothing", {31'd0, reg_rdata[31]}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule